// File: doc/BRIEF.md
# Byte-Addressable Peripheral Register Slave with OR-Combined Read Bus

This block is a register slave for a simple 16-bit peripheral bus with word addressing. Each slave owns a window of four 16-bit registers that starts at a base word address set by a parameter. The four registers are a control word, a read-only status word, a data word and a scratch word. The bus master presents a 14-bit word address, an active-high access enable, a 2-bit active-high byte write strobe and a write word. Software sees byte addresses equal to twice the word address.

Reads are combinational. While the enable is high and the address falls inside the window, the selected register appears on the read bus in that same cycle. In every other case the slave drives all zeros. The top level instantiates several slaves at distinct bases and merges their read buses with a bitwise OR, which is safe because only the addressed slave ever drives a non-zero value. A write is byte-granular and is committed at the next rising clock edge.

Top module: `pbus_pair`

## Requirements
- R1: A clock edge with `rst_n` low clears control, data and scratch to zero in every slave.
- R2: While `bus_en` is high and the address hits a register, `bus_rdata` equals that register's current value in the same cycle.
- R3: While `bus_en` is low, `bus_rdata` is all zeros whatever the address.
- R4: An address outside every slave's window gives `bus_rdata` of all zeros, including the words just below a base and just past base+3.
- R5: Write strobe bit 0 writes bits 7:0 and bit 1 writes bits 15:8; a cleared strobe bit leaves that byte unchanged, and strobe 2'b00 changes nothing.
- R6: A write is committed on the rising edge that ends the access, so a read of the same register during the write cycle returns the old value.
- R7: The status word is read-only and reads {slave ID in bits 15:8, zeros in bits 7:1, bit 0 = 1 when the data word is non-zero}; a write to it changes no register.
- R8: The scratch word reads back exactly the bytes written to it.
- R9: Register word offsets from the base: 0 control, 1 status, 2 data, 3 scratch.
- R10: Slave 0 sits at word base 0x0040 with ID 0xA1 and slave 1 at 0x0100 with ID 0xB2; at most one slave is hit at a time, and a write to one slave never alters the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Access enable, active high |
| bus_addr | input | 14 | Word address |
| bus_we | input | 2 | Byte write strobe, active high (bit 0 low byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | OR of all slaves' read data, combinational |

## Verification
The hardest case to reach from the ports is a write whose effect must not be seen yet. The value on the read bus in the write cycle itself has to be the old one, and the new value has to appear only after the edge. Every write in the bench is also a read of the same register, and the read bus is sampled between the drive and the edge. A second hard case is a write that must not leak between slaves. This is shown by sweeping the whole 14-bit address space against a model holding different contents in the two slaves, once after the byte-lane writes and once after a status write that must be ignored.

// File: rtl/pbus_pkg.sv
// Package: shared widths and the register index type for the peripheral
// register slave. Assumes a 16-bit data bus made of 8-bit lanes.
package pbus_pkg;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int STRB_W = DATA_W / LANE_W;
    localparam int NREG   = 4;
    localparam int OFF_W  = $clog2(NREG);

    typedef enum logic [OFF_W-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_SCR  = 2'd3
    } reg_idx_e;
endpackage

// File: rtl/pbus_decode.sv
// Module: pbus_decode
// Turns a word address into a window hit and a register index.
// Assumes that BASE + NREG - 1 fits in the address width. BASE need not
// be aligned to NREG.
module pbus_decode
    import pbus_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_idx_e          idx
);
    localparam logic [ADDR_W:0] LIMIT = {1'b0, BASE} + NREG;

    logic [ADDR_W-1:0] rel;

    // Offset of the address from the base, and the window test.
    always_comb begin
        rel = addr - BASE;
        hit = en && ({1'b0, addr} >= {1'b0, BASE}) && ({1'b0, addr} < LIMIT);
        idx = reg_idx_e'(rel[OFF_W-1:0]);
    end
endmodule

// File: rtl/pbus_regbank.sv
// Module: pbus_regbank
// Holds the writable registers (control, data, scratch) and forms the
// read-only status word. A write goes to the byte lanes whose strobe bit is
// set and is committed at the clock edge. Assumes that wr_sel is already
// qualified by the enable and the window hit.
module pbus_regbank
    import pbus_pkg::*;
#(
    parameter logic [LANE_W-1:0] ID = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  reg_idx_e          idx,
    input  logic [STRB_W-1:0] we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] stat_w,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] scr_q
);
    logic [DATA_W-1:0] lane_mask;
    logic              wr;

    // Widen each strobe bit into a mask for its byte lane.
    for (genvar b = 0; b < STRB_W; b++) begin : g_lane
        assign lane_mask[b*LANE_W +: LANE_W] = {LANE_W{we[b]}};
    end

    assign wr = wr_sel && (|we);

    // Byte-merge the write into the register the index selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            data_q <= '0;
            scr_q  <= '0;
        end else if (wr) begin
            unique case (idx)
                REG_CTRL: ctrl_q <= (ctrl_q & ~lane_mask) | (wdata & lane_mask);
                REG_DATA: data_q <= (data_q & ~lane_mask) | (wdata & lane_mask);
                REG_SCR:  scr_q  <= (scr_q  & ~lane_mask) | (wdata & lane_mask);
                default:  ;
            endcase
        end
    end

    // Status word: the ID byte, then a flag for a non-zero data word.
    always_comb begin
        stat_w = '0;
        stat_w[DATA_W-1 -: LANE_W] = ID;
        stat_w[0] = |data_q;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0) && (data_q == '0) && (scr_q == '0));

    a_r7_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == REG_STAT) |=> $stable(ctrl_q) && $stable(data_q) && $stable(scr_q));

    a_r5_no_strobe_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ctrl_q) && $stable(data_q) && $stable(scr_q));

    a_r5_low_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == REG_SCR && we == 2'b01) |=>
        (scr_q[15:8] == $past(scr_q[15:8])) && (scr_q[7:0] == $past(wdata[7:0])));
endmodule

// File: rtl/pbus_slave.sv
// Module: pbus_slave
// One register slave: window decode, register bank and a combinational
// read mux that drives zero unless this slave is hit. Assumes that the
// caller ORs its read data with that of the other slaves.
module pbus_slave
    import pbus_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter logic [LANE_W-1:0] ID   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [STRB_W-1:0] we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              hit
);
    reg_idx_e          idx;
    logic [DATA_W-1:0] ctrl_q, stat_w, data_q, scr_q;

    pbus_decode #(.BASE(BASE)) u_dec (
        .en   (en),
        .addr (addr),
        .hit  (hit),
        .idx  (idx)
    );

    pbus_regbank #(.ID(ID)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (hit),
        .idx    (idx),
        .we     (we),
        .wdata  (wdata),
        .ctrl_q (ctrl_q),
        .stat_w (stat_w),
        .data_q (data_q),
        .scr_q  (scr_q)
    );

    // Same-cycle read mux, forced to zero when not selected.
    always_comb begin
        rdata = '0;
        if (hit) begin
            unique case (idx)
                REG_CTRL: rdata = ctrl_q;
                REG_STAT: rdata = stat_w;
                REG_DATA: rdata = data_q;
                REG_SCR:  rdata = scr_q;
                default:  rdata = '0;
            endcase
        end
    end

    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (rdata == '0));

    a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (rdata == '0));
endmodule

// File: rtl/pbus_pair.sv
// Module: pbus_pair
// Places NSLV register slaves at distinct bases and merges their read
// buses with a bitwise OR. Assumes that the windows do not overlap.
module pbus_pair
    import pbus_pkg::*;
#(
    parameter int                       NSLV  = 2,
    parameter logic [NSLV*ADDR_W-1:0]   BASES = {14'h0100, 14'h0040},
    parameter logic [NSLV*LANE_W-1:0]   IDS   = {8'hB2, 8'hA1}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic [13:0]       bus_addr,
    input  logic [1:0]        bus_we,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata
);
    logic [DATA_W-1:0] slv_rdata [NSLV];
    logic [NSLV-1:0]   slv_hit;

    for (genvar s = 0; s < NSLV; s++) begin : g_slv
        pbus_slave #(
            .BASE (BASES[s*ADDR_W +: ADDR_W]),
            .ID   (IDS[s*LANE_W +: LANE_W])
        ) u_slv (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bus_en),
            .addr  (bus_addr),
            .we    (bus_we),
            .wdata (bus_wdata),
            .rdata (slv_rdata[s]),
            .hit   (slv_hit[s])
        );
    end

    // Wired-OR of all slave read buses.
    always_comb begin
        bus_rdata = '0;
        for (int s = 0; s < NSLV; s++) begin
            bus_rdata = bus_rdata | slv_rdata[s];
        end
    end

    a_r10_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slv_hit));
endmodule

// File: tb/pbus_pair_test.sv
// Bench for pbus_pair: reference model of both slaves, byte-lane sweeps,
// and full address-space read sweeps.
module pbus_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [1:0]  bus_we = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [13:0] BASE [2] = '{14'h0040, 14'h0100};
    localparam logic [7:0]  ID   [2] = '{8'hA1, 8'hB2};

    logic [15:0] m_ctrl [2];
    logic [15:0] m_data [2];
    logic [15:0] m_scr  [2];

    pbus_pair uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] exp_reg(int s, int off);
        case (off)
            0: return m_ctrl[s];
            1: return {ID[s], 7'b0, (m_data[s] != 16'h0)};
            2: return m_data[s];
            default: return m_scr[s];
        endcase
    endfunction

    function automatic logic [15:0] exp_read(logic [13:0] a);
        for (int s = 0; s < 2; s++) begin
            if (a >= BASE[s] && a < BASE[s] + 14'd4) return exp_reg(s, int'(a - BASE[s]));
        end
        return 16'h0;
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, bus_addr, got, exp);
        end
    endtask

    // Read one word at a negative edge and check it.
    task automatic rd(string req, logic [13:0] a);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 2'b00; bus_addr = a;
        #1 check(req, bus_rdata, exp_read(a));
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    // Write with strobe; checks R6 (old value during the write cycle).
    task automatic wr(int s, int off, logic [1:0] we, logic [15:0] d);
        logic [15:0] mask;
        logic [15:0] nv;
        @(negedge clk);
        bus_en = 1'b1; bus_we = we; bus_wdata = d; bus_addr = BASE[s] + 14'(off);
        #1 check("R6", bus_rdata, exp_reg(s, off));
        mask = {{8{we[1]}}, {8{we[0]}}};
        nv = (exp_reg(s, off) & ~mask) | (d & mask);
        case (off)
            0: m_ctrl[s] = nv;
            2: m_data[s] = nv;
            3: m_scr[s]  = nv;
            default: ;
        endcase
        @(negedge clk);
        bus_en = 1'b0; bus_we = 2'b00;
    endtask

    task automatic sweep(string req);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 2'b00;
        for (int a = 0; a < 16384; a++) begin
            bus_addr = 14'(a);
            #1 check(req, bus_rdata, exp_read(14'(a)));
        end
        bus_en = 1'b0;
    endtask

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_ctrl[s] = '0; m_data[s] = '0; m_scr[s] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R9: reset values at each offset of each slave.
        for (int s = 0; s < 2; s++)
            for (int o = 0; o < 4; o++) rd("R1_R9", BASE[s] + 14'(o));

        // R5 / R8: every strobe pattern on every writable register.
        for (int s = 0; s < 2; s++) begin
            for (int o = 0; o < 4; o++) begin
                if (o == 1) continue;
                for (int w = 0; w < 4; w++) begin
                    wr(s, o, 2'(w), 16'h1111 * 16'(w + 1) ^ 16'(s * 16'h5A00 + o));
                    rd((o == 3) ? "R8" : "R5", BASE[s] + 14'(o));
                end
            end
        end

        // R7: status write with both lanes changes nothing.
        for (int s = 0; s < 2; s++) begin
            wr(s, 1, 2'b11, 16'hFFFF);
            for (int o = 0; o < 4; o++) rd("R7", BASE[s] + 14'(o));
        end

        // R2 / R4 / R10: full address sweep, window edges included.
        sweep("R2_R4_R10");

        // R10: slave 0 writes leave slave 1 intact; data zero clears flag.
        wr(0, 2, 2'b11, 16'h0000);
        wr(0, 3, 2'b10, 16'hC300);
        sweep("R10");

        // R3: enable low with every window address gives zero.
        for (int s = 0; s < 2; s++) begin
            for (int o = -1; o < 5; o++) begin
                @(negedge clk);
                bus_en = 1'b0; bus_addr = BASE[s] + 14'(o);
                #1 check("R3", bus_rdata, 16'h0);
            end
        end

        // R1: reset in the middle of operation.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 2; s++) begin
            m_ctrl[s] = '0; m_data[s] = '0; m_scr[s] = '0;
            for (int o = 0; o < 4; o++) rd("R1", BASE[s] + 14'(o));
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule